// File: doc/BRIEF.md
# Parallel ADC Conversion and Read Sequencer

This block sits on the host side of a 16-bit successive-approximation converter that has a parallel output bus. It owns the four control strobes of that converter: an active-low convert-start, an active-low chip select, an active-low read and a byte-fold select. It also watches the converter's busy flag. A conversion starts on a one-cycle start request, or on an internal rate tick when free-running is enabled. The block then waits for busy to drop and reads the result. The read is either a single 16-bit word or two 8-bit halves taken from the upper eight data lines. The assembled result appears as a signed sample together with a one-cycle valid pulse.

Every timing limit of the converter is a nanosecond parameter. Each one is turned into a clock-cycle count at elaboration, rounded up. These limits are the convert-start low and high widths, the minimum spacing between conversions, the read quiet zone around the sampling edge, and the data-valid delays after a read or a byte flip. The busy flag is asynchronous to the system clock, so it goes through a two-stage synchronizer. If busy never falls, a sticky timeout flag is raised and the sequencer returns to idle.

Top module: `adc_par_reader`

## Requirements
- R1: While reset is active and right after it, adcConvStN, adcCsN and adcRdN are high, and adcByteSel, sampleValid and busyTimeout are low.
- R2: A start request seen in idle, with every spacing window met, drives adcConvStN low on the next rising clock edge. adcConvStN then stays low for at least 20 ns (3 cycles at 125 MHz).
- R3: adcConvStN is high for at least 100 ns before each falling edge. Consecutive falling edges are at least 250 ns apart, even when the start request is held high.
- R4: No adcCsN or adcRdN transition occurs in the window from 30 ns before to 10 ns after a falling edge of adcConvStN. Chip select and read stay high while adcConvStN is low.
- R5: A read begins only after the synchronized adcBusy has been seen high and then low. adcCsN and adcRdN fall on the same edge and stay low for at least 17 ns before any data is taken.
- R6: In 16-bit mode (byteMode low when the conversion starts), adcByteSel stays low and all sixteen data lines are taken as the sample in one read.
- R7: In 8-bit mode (byteMode high when the conversion starts), the first read takes lines 15..8 as sample bits 15..8. adcByteSel then rises, and at least 20 ns later lines 15..8 are taken as sample bits 7..0.
- R8: The sample is two's complement: 0x7FFF is +32767, 0x8000 is -32768 and 0xFFFF is -1. sampleValid is high for exactly one cycle per completed conversion.
- R9: A start request or a rate tick that arrives while a conversion or read is in progress is dropped. It never causes an extra conversion.
- R10: While freeRun is high, a conversion starts once per RATE_CYCLES clocks, on each rate tick, provided the previous cycle has finished.
- R11: If busy has not fallen within BUSY_TIMEOUT cycles after adcConvStN returns high, busyTimeout is set and held until reset. All strobes return to their inactive levels and no sampleValid is issued. Later conversions still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one conversion |
| freeRun | input | 1 | Start conversions from the internal rate tick |
| byteMode | input | 1 | 1: two 8-bit reads, 0: one 16-bit read (taken at conversion start) |
| adcBusy | input | 1 | Converter busy flag, asynchronous |
| adcData | input | 16 | Converter data lines |
| adcConvStN | output | 1 | Convert-start strobe, active low |
| adcCsN | output | 1 | Chip select, active low |
| adcRdN | output | 1 | Read strobe, active low |
| adcByteSel | output | 1 | High: low byte folded onto lines 15..8 |
| sample | output | 16 | Signed conversion result |
| sampleValid | output | 1 | One-cycle pulse with a new sample |
| busyTimeout | output | 1 | Sticky flag: busy never fell |

## Verification
Two events can fall in the same cycle. One is a new trigger, either a start request or a rate tick. The other is the tail of the previous cycle: the final capture, the release of chip select and read, or the expiry of the timeout. The bench holds the start request high for a long stretch and also pulses it during the busy wait. In both cases triggers land on those last cycles. Time-stamped monitors then check that each following convert-start fall still respects the 100 ns high width, the 250 ns spacing and the 30 ns quiet window. The falling edges of convert-start are counted against the samples delivered, so an extra or lost conversion shows up as a mismatch.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAIT,
    ST_RD1,
    ST_RD2,
    ST_END
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capWord;
    logic capHigh;
    logic capLow;
  } dpStrobe_t;

  // nanoseconds to cycles, rounded up, never below one
  function automatic int nsToCyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcrd_datapath.sv
module adcrd_datapath
  import adcrd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] dataBus,
  input  dpStrobe_t         stb,
  output logic              busyFall,
  output logic [DATA_W-1:0] sample,
  output logic              sampleValid
);

  localparam int HALF_W = DATA_W / 2;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   busyPrev;
  logic [HALF_W-1:0]      hiByte;

  // busy synchronizer, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain[0] <= 1'b0;
        else       syncChain[0] <= busyIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain[g] <= 1'b0;
        else       syncChain[g] <= syncChain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) busyPrev <= 1'b0;
    else       busyPrev <= syncChain[SYNC_STAGES-1];

  assign busyFall = busyPrev & ~syncChain[SYNC_STAGES-1];

  // result assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiByte      <= '0;
      sample      <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (stb.capWord) begin
        sample      <= dataBus;
        sampleValid <= 1'b1;
      end
      if (stb.capHigh) hiByte <= dataBus[DATA_W-1:HALF_W];
      if (stb.capLow) begin
        sample      <= {hiByte, dataBus[DATA_W-1:HALF_W]};
        sampleValid <= 1'b1;
      end
    end
  end

  // R8: valid is a single-cycle pulse
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R6: at most one capture strobe per cycle from the control side
  assert_one_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capWord, stb.capHigh, stb.capLow}));

endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int CLK_MHZ      = 125,
  parameter int LOW_NS       = 20,
  parameter int HIGH_NS      = 100,
  parameter int PERIOD_NS    = 250,
  parameter int QPRE_NS      = 30,
  parameter int QPOST_NS     = 10,
  parameter int RDV_NS       = 17,
  parameter int BYV_NS       = 20,
  parameter int BUSY_TIMEOUT = 64,
  parameter int RATE_CYCLES  = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      freeRun,
  input  logic      byteMode,
  input  logic      busyFall,
  output logic      convStN,
  output logic      csN,
  output logic      rdN,
  output logic      byteSel,
  output dpStrobe_t dpStb,
  output logic      busyTimeout
);

  localparam int LOW_CYC    = nsToCyc(LOW_NS, CLK_MHZ);
  localparam int HIGH_CYC   = nsToCyc(HIGH_NS, CLK_MHZ);
  localparam int PERIOD_CYC = nsToCyc(PERIOD_NS, CLK_MHZ);
  localparam int QPRE_CYC   = nsToCyc(QPRE_NS, CLK_MHZ);
  localparam int QPOST_CYC  = nsToCyc(QPOST_NS, CLK_MHZ);
  localparam int RDV_CYC    = nsToCyc(RDV_NS, CLK_MHZ);
  localparam int BYV_CYC    = nsToCyc(BYV_NS, CLK_MHZ);
  localparam int TO_CYC     = (BUSY_TIMEOUT < 1) ? 1 : BUSY_TIMEOUT;
  localparam int RATE_CYC   = (RATE_CYCLES < 1) ? 1 : RATE_CYCLES;

  localparam int MAX_CYC = maxOf(maxOf(maxOf(LOW_CYC, HIGH_CYC), maxOf(PERIOD_CYC, QPRE_CYC)),
                                 maxOf(maxOf(QPOST_CYC, RDV_CYC), maxOf(BYV_CYC, TO_CYC)));
  localparam int CNT_W  = $clog2(MAX_CYC + 2);
  localparam int RATE_W = $clog2(RATE_CYC + 1);

  localparam logic [CNT_W-1:0]  CNT_SAT    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  LOW_LIM    = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0]  HIGH_LIM   = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0]  PERIOD_LIM = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0]  QPRE_LIM   = CNT_W'(QPRE_CYC - 1);
  localparam logic [CNT_W-1:0]  QPOST_LIM  = CNT_W'(QPOST_CYC - 1);
  localparam logic [CNT_W-1:0]  RDV_LIM    = CNT_W'(RDV_CYC - 1);
  localparam logic [CNT_W-1:0]  BYV_LIM    = CNT_W'(BYV_CYC - 1);
  localparam logic [CNT_W-1:0]  TO_LIM     = CNT_W'(TO_CYC - 1);
  localparam logic [RATE_W-1:0] RATE_LIM   = RATE_W'(RATE_CYC - 1);

  ctlState_t         state, stateNext;
  logic [CNT_W-1:0]  cnt, periodCnt, highCnt, quietCnt;
  logic [RATE_W-1:0] rateCnt;
  logic pending, doneSeen, modeByte;
  logic rateTick, trigNow, timingOk, cntClr, setTimeout, goConv;

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_SAT) ? v : v + 1'b1;
  endfunction

  assign rateTick = freeRun && (rateCnt == RATE_LIM);
  assign trigNow  = startReq | rateTick;
  assign timingOk = (periodCnt >= PERIOD_LIM) && (highCnt >= HIGH_LIM) &&
                    (quietCnt >= QPRE_LIM);

  always_comb begin
    stateNext  = state;
    cntClr     = 1'b0;
    setTimeout = 1'b0;
    goConv     = 1'b0;
    dpStb      = '0;
    case (state)
      ST_IDLE: if ((pending || trigNow) && timingOk) begin
        stateNext = ST_LOW;
        goConv    = 1'b1;
        cntClr    = 1'b1;
      end
      ST_LOW: if (cnt == LOW_LIM) begin
        stateNext = ST_WAIT;
        cntClr    = 1'b1;
      end
      ST_WAIT: begin
        if (doneSeen && periodCnt >= QPOST_LIM) begin
          stateNext = ST_RD1;
          cntClr    = 1'b1;
        end else if (!doneSeen && cnt == TO_LIM) begin
          stateNext  = ST_IDLE;
          setTimeout = 1'b1;
        end
      end
      ST_RD1: if (cnt == RDV_LIM) begin
        cntClr = 1'b1;
        if (modeByte) begin
          dpStb.capHigh = 1'b1;
          stateNext     = ST_RD2;
        end else begin
          dpStb.capWord = 1'b1;
          stateNext     = ST_END;
        end
      end
      ST_RD2: if (cnt == BYV_LIM) begin
        dpStb.capLow = 1'b1;
        stateNext    = ST_END;
      end
      ST_END:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      periodCnt   <= CNT_SAT;
      highCnt     <= CNT_SAT;
      quietCnt    <= CNT_SAT;
      rateCnt     <= '0;
      pending     <= 1'b0;
      doneSeen    <= 1'b0;
      modeByte    <= 1'b0;
      busyTimeout <= 1'b0;
      convStN     <= 1'b1;
      csN         <= 1'b1;
      rdN         <= 1'b1;
      byteSel     <= 1'b0;
    end else begin
      state     <= stateNext;
      cnt       <= (cntClr || state == ST_IDLE) ? '0 : cnt + 1'b1;
      periodCnt <= goConv ? '0 : satInc(periodCnt);
      highCnt   <= (state == ST_LOW) ? '0 : satInc(highCnt);
      quietCnt  <= (state == ST_RD1 || state == ST_RD2) ? '0 : satInc(quietCnt);
      rateCnt   <= (!freeRun || rateTick) ? '0 : rateCnt + 1'b1;
      pending   <= goConv ? 1'b0 : ((state == ST_IDLE) ? (pending | trigNow) : 1'b0);
      if (goConv)                             doneSeen <= 1'b0;
      else if (state == ST_WAIT && busyFall)  doneSeen <= 1'b1;
      if (goConv) modeByte <= byteMode;
      busyTimeout <= busyTimeout | setTimeout;
      convStN <= (stateNext != ST_LOW);
      csN     <= !(stateNext == ST_RD1 || stateNext == ST_RD2);
      rdN     <= !(stateNext == ST_RD1 || stateNext == ST_RD2);
      byteSel <= (stateNext == ST_RD2);
    end
  end

  // R2: convert-start held low beyond its falling cycle
  if (LOW_CYC >= 2) begin : gLowChk
    assert_low_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      $fell(convStN) |=> !convStN);
  end

  // R3: spacing window met before every fall
  assert_period_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convStN) |-> ($past(periodCnt) >= PERIOD_LIM));

  // R4: no read activity while convert-start is low
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !convStN |-> (csN && rdN));

  // R5: a read opens only after busy was seen falling
  assert_read_after_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(doneSeen));

  // R7: byte fold only inside a read
  assert_bytesel_in_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    byteSel |-> !csN);

  // R11: timeout flag is sticky
  assert_timeout_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    busyTimeout |=> busyTimeout);

endmodule

// File: rtl/adc_par_reader.sv
module adc_par_reader
  import adcrd_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int CLK_MHZ      = 125,
  parameter int LOW_NS       = 20,
  parameter int HIGH_NS      = 100,
  parameter int PERIOD_NS    = 250,
  parameter int QPRE_NS      = 30,
  parameter int QPOST_NS     = 10,
  parameter int RDV_NS       = 17,
  parameter int BYV_NS       = 20,
  parameter int BUSY_TIMEOUT = 64,
  parameter int RATE_CYCLES  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              freeRun,
  input  logic              byteMode,
  input  logic              adcBusy,
  input  logic [DATA_W-1:0] adcData,
  output logic              adcConvStN,
  output logic              adcCsN,
  output logic              adcRdN,
  output logic              adcByteSel,
  output logic [DATA_W-1:0] sample,
  output logic              sampleValid,
  output logic              busyTimeout
);

  dpStrobe_t dpStb;
  logic      busyFall;

  adcrd_ctrl #(
    .CLK_MHZ(CLK_MHZ), .LOW_NS(LOW_NS), .HIGH_NS(HIGH_NS), .PERIOD_NS(PERIOD_NS),
    .QPRE_NS(QPRE_NS), .QPOST_NS(QPOST_NS), .RDV_NS(RDV_NS), .BYV_NS(BYV_NS),
    .BUSY_TIMEOUT(BUSY_TIMEOUT), .RATE_CYCLES(RATE_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .byteMode(byteMode), .busyFall(busyFall), .convStN(adcConvStN),
    .csN(adcCsN), .rdN(adcRdN), .byteSel(adcByteSel), .dpStb(dpStb),
    .busyTimeout(busyTimeout)
  );

  adcrd_datapath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .busyIn(adcBusy), .dataBus(adcData), .stb(dpStb),
    .busyFall(busyFall), .sample(sample), .sampleValid(sampleValid)
  );

endmodule

// File: tb/tb_adc_par_reader.sv
`timescale 1ns/100ps
module tb_adc_par_reader;

  localparam int RATE = 60;
  localparam int TOUT = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, freeRun = 1'b0, byteMode = 1'b0;
  logic adcBusy = 1'b0;
  logic [15:0] adcData = 16'hC3C3;
  logic adcConvStN, adcCsN, adcRdN, adcByteSel, sampleValid, busyTimeout;
  logic [15:0] sample;

  int checks = 0, errors = 0;
  int nFall = 0, nValid = 0;
  bit busyEn = 1'b1;
  logic [15:0] nextCode = 16'h0000;
  logic [15:0] outReg = 16'h0000;
  logic [15:0] expQ[$];
  bit modeQ[$];
  real tEn = -1000.0, tByte = -1000.0, tFall = -1000.0, tRise = -1000.0;
  real tBusyFall = -1000.0, tFrLast = -1000.0;
  bit frMon = 1'b0, frHave = 1'b0, curMode8 = 1'b0, prevValid = 1'b0, prevCs = 1'b1;

  always #4 clk = ~clk;

  adc_par_reader #(.CLK_MHZ(125), .BUSY_TIMEOUT(TOUT), .RATE_CYCLES(RATE)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun), .byteMode(byteMode),
    .adcBusy(adcBusy), .adcData(adcData), .adcConvStN(adcConvStN), .adcCsN(adcCsN),
    .adcRdN(adcRdN), .adcByteSel(adcByteSel), .sample(sample), .sampleValid(sampleValid),
    .busyTimeout(busyTimeout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // converter model: busy 4 ns after the fall, result after 180 ns
  always @(negedge adcConvStN) begin
    if (rstN && busyEn) begin
      logic [15:0] code;
      code = nextCode;
      expQ.push_back(code);
      modeQ.push_back(byteMode);
      curMode8 = byteMode;
      #4 adcBusy = 1'b1;
      #176 outReg = code;
      adcBusy = 1'b0;
      tBusyFall = $realtime;
    end
  end

  always @(adcCsN or adcRdN) tEn = $realtime;
  always @(adcByteSel) tByte = $realtime;

  // data lines: junk until the valid delays have passed
  initial begin
    #0.5;
    forever begin
      #1;
      if (!adcCsN && !adcRdN && ($realtime - tEn) >= 17.0 && ($realtime - tByte) >= 20.0)
        adcData = adcByteSel ? {outReg[7:0], 8'hFF} : outReg;
      else
        adcData = 16'hC3C3;
    end
  end

  // convert-start timing monitors
  always @(negedge adcConvStN) if (rstN) begin
    nFall++;
    chk(($realtime - tRise) >= 100.0, "R3", "high width ns", int'($realtime - tRise), 100);
    chk(($realtime - tFall) >= 250.0, "R3", "fall spacing ns", int'($realtime - tFall), 250);
    chk(($realtime - tEn) >= 30.0, "R4", "read edge before fall ns", int'($realtime - tEn), 30);
    if (frMon && frHave)
      chk(($realtime - tFrLast) == RATE * 8.0, "R10", "free-run interval ns",
          int'($realtime - tFrLast), RATE * 8);
    if (frMon) begin frHave = 1'b1; tFrLast = $realtime; end
    tFall = $realtime;
  end

  always @(posedge adcConvStN) if (rstN && tFall > 0.0) begin
    chk(($realtime - tFall) >= 20.0, "R2", "low width ns", int'($realtime - tFall), 20);
    tRise = $realtime;
  end

  always @(adcCsN or adcRdN) if (rstN && tFall > 0.0)
    chk(($realtime - tFall) >= 10.0, "R4", "read edge after fall ns", int'($realtime - tFall), 10);

  always @(posedge adcByteSel) if (rstN) begin
    chk(curMode8, "R6", "byte select in word mode", 1, 0);
    chk(!adcCsN, "R7", "byte select outside read", adcCsN, 0);
  end

  // per-clock comparisons, away from the active edge
  always @(negedge clk) if (rstN) begin
    if (prevCs && !adcCsN) begin
      chk(!adcRdN, "R5", "read strobe with select", adcRdN, 0);
      chk(!adcBusy, "R5", "busy low at read", adcBusy, 0);
      chk(($realtime - tBusyFall) >= 16.0, "R5", "busy sync delay ns",
          int'($realtime - tBusyFall), 16);
    end
    prevCs = adcCsN;
    if (sampleValid) begin
      nValid++;
      chk(!prevValid, "R8", "valid longer than a cycle", 1, 0);
      if (expQ.size() == 0) chk(1'b0, "R8", "unexpected sample", sample, 0);
      else begin
        logic [15:0] e;
        bit m;
        e = expQ.pop_front();
        m = modeQ.pop_front();
        chk($signed(sample) == $signed(e), m ? "R7" : "R6", "sample value", sample, e);
      end
    end
    prevValid = sampleValid;
  end

  task automatic startOne();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    chk(!adcConvStN, "R2", "convert-start one edge after request", adcConvStN, 0);
  endtask

  task automatic waitValid();
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (sampleValid) break;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic convertOne(input logic [15:0] code, input bit mode8);
    int v0;
    v0 = nValid;
    nextCode = code;
    byteMode = mode8;
    startOne();
    waitValid();
    chk(nValid == v0 + 1, "R8", "one valid per conversion", nValid - v0, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(adcConvStN && adcCsN && adcRdN && !adcByteSel && !sampleValid && !busyTimeout,
        "R1", "strobes in reset", {adcConvStN, adcCsN, adcRdN, adcByteSel, sampleValid, busyTimeout},
        6'b111000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(adcConvStN && adcCsN && adcRdN && !adcByteSel && !busyTimeout, "R1", "idle after reset",
        {adcConvStN, adcCsN, adcRdN, adcByteSel, busyTimeout}, 5'b11100);

    // word mode, full-scale and sign corners
    convertOne(16'h7FFF, 1'b0);
    convertOne(16'h8000, 1'b0);
    chk($signed(sample) == -32768, "R8", "negative full scale", sample, 16'h8000);
    convertOne(16'hFFFF, 1'b0);
    chk($signed(sample) == -1, "R8", "one below midscale", sample, 16'hFFFF);
    convertOne(16'h1234, 1'b0);

    // folded two-read mode
    convertOne(16'hA55A, 1'b1);
    convertOne(16'h80FF, 1'b1);
    convertOne(16'h017E, 1'b1);

    // start held high: triggers collide with read tails
    begin
      int f0;
      f0 = nFall;
      nextCode = 16'h4321;
      byteMode = 1'b0;
      @(negedge clk) startReq = 1'b1;
      repeat (150) @(negedge clk);
      startReq = 1'b0;
      repeat (80) @(negedge clk);
      chk(nFall - f0 >= 3, "R3", "back-to-back conversions", nFall - f0, 3);
      chk(expQ.size() == 0, "R8", "samples outstanding", expQ.size(), 0);
    end

    // requests during a conversion are dropped
    begin
      int f0, v0;
      f0 = nFall;
      v0 = nValid;
      nextCode = 16'h0C0C;
      startOne();
      repeat (5) @(negedge clk);
      for (int i = 0; i < 10; i++) begin
        startReq = 1'b1;
        @(negedge clk) startReq = 1'b0;
      end
      repeat (80) @(negedge clk);
      chk(nFall - f0 == 1, "R9", "convert-start count", nFall - f0, 1);
      chk(nValid - v0 == 1, "R9", "sample count", nValid - v0, 1);
    end

    // free-running rate
    begin
      int f0;
      f0 = nFall;
      nextCode = 16'h2468;
      frMon = 1'b1;
      frHave = 1'b0;
      @(negedge clk) freeRun = 1'b1;
      repeat (RATE * 5 + 5) @(negedge clk);
      freeRun = 1'b0;
      frMon = 1'b0;
      repeat (80) @(negedge clk);
      chk(nFall - f0 == 5, "R10", "free-run conversions", nFall - f0, 5);
    end

    // busy never falls
    begin
      int v0;
      v0 = nValid;
      busyEn = 1'b0;
      startOne();
      repeat (TOUT + 20) @(negedge clk);
      chk(busyTimeout, "R11", "timeout flag", busyTimeout, 1);
      chk(adcCsN && adcRdN && adcConvStN && !adcByteSel, "R11", "strobes released",
          {adcCsN, adcRdN, adcConvStN, adcByteSel}, 4'b1110);
      chk(nValid == v0, "R11", "no sample on timeout", nValid - v0, 0);
      busyEn = 1'b1;
      convertOne(16'h0F0F, 1'b0);
      chk(busyTimeout, "R11", "timeout stays set", busyTimeout, 1);
    end

    finishRun();
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog R1 run did not complete actual=1 expected=0");
    finishRun();
  end

endmodule